// File: doc/BRIEF.md
# Capture-Compare Timer with Waveform Output

A 32-bit up-counter on a small memory-mapped register bus. It runs from the bus clock, either on every cycle or through a power-of-two prescaler. On wrap-around it either reloads from a programmable load value or halts itself. A compare register raises a match event when the counter steps onto its value. A capture unit records the counter value on selected edges of an input pin, into one register or into two in turn. A waveform pin pulses or toggles on overflow alone, or on overflow and match, around a programmable idle level.

Three sticky event flags, for match, overflow and capture, are cleared by writing one to them. The interrupt line is the OR of the flags whose enable bits are set. Software starts a run by writing the counter first and then the control word with the start bit set. It stops the run by clearing only the start bit, which also clears a pending overflow flag.

Register offsets: status 0x04, interrupt enable 0x08, control 0x24, counter 0x28, load 0x2C, reload strobe 0x30, compare 0x38, first capture 0x3C, second capture 0x44. The strobe reads as zero. Reads are combinational from `bus_addr`. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. The capture pin is assumed synchronous to `clk`.

Top module: `cc_timer`

## Requirements
- R1: After reset, control, counter, status, enable and both capture registers read 0, and `irq` and `pwm_out` are 0.
- R2: While control bit 0 (run) is set and the prescaler is off (bit 5 clear), the counter advances by one on every clock. A bus write to the counter loads the written value and has priority over counting. While run is clear the counter holds.
- R3: With control bit 5 set, the counter advances once every 2^(P+1) clocks, where P is control bits 4:2. Two advances are never on adjacent clocks.
- R4: When the counter steps from 0xFFFFFFFF with control bit 1 (reload) set, it takes the load register value and status bit 1 (overflow) is set.
- R5: When the counter steps from 0xFFFFFFFF with reload clear, it becomes 0, the run bit clears by itself, and status bit 1 is set.
- R6: Any write to the reload strobe at 0x30 copies the load register into the counter, whatever the data written.
- R7: With control bit 6 set, status bit 0 (match) is set when the counter steps onto the compare value. With bit 6 clear, no match is flagged.
- R8: Control bits 9:8 choose the capture edge: 0 none, 1 rising, 2 falling, 3 both. A qualifying edge stores the counter value of that cycle, and edges of the other kinds are ignored.
- R9: With control bit 13 clear, only the first qualifying edge is stored (first capture) and it sets status bit 2. With bit 13 set, the first edge fills the first capture register and the second fills the second capture register, which sets status bit 2. Later edges are ignored until status bit 2 is cleared.
- R10: Writing to status clears exactly the bits written as 1. Bits written as 0 stay as they are.
- R11: `irq` is high exactly when some status bit and the same enable bit (0x08) are both set.
- R12: A control write that changes run from 1 to 0 clears status bit 1 and stores the other control bits as written. A control write while already stopped leaves status bit 1 alone.
- R13: Control bits 11:10 choose the output events: 0 none, 1 overflow, 2 overflow or match. With bit 12 clear, `pwm_out` equals control bit 7 (idle level) inverted for one cycle per event. With bit 12 set, `pwm_out` flips on each event while running, starting from the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cap_in | input | 1 | Capture input pin |
| pwm_out | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is tried with a free run, a prescaled run, a wrap with reload, a wrap without reload, and a strobe reload. Together these separate the increment, the divider period, the two overflow branches and the reload source. The capture pin is driven with rising and falling edges under each edge selection and in both capture modes. A stored value that changes after the first edge shows whether later edges are ignored, and an edge of the wrong kind shows whether it is filtered. The waveform pin is observed in toggle and pulse modes, with match placed just before overflow. This tells the overflow-only trigger apart from the overflow-or-match trigger, and shows whether the idle level inverts the output.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h08;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h24;
  localparam logic [ADDR_W-1:0] A_CNT  = 8'h28;
  localparam logic [ADDR_W-1:0] A_LOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] A_TRG  = 8'h30;
  localparam logic [ADDR_W-1:0] A_MAT  = 8'h38;
  localparam logic [ADDR_W-1:0] A_CAP1 = 8'h3C;
  localparam logic [ADDR_W-1:0] A_CAP2 = 8'h44;

  localparam int ST_MAT = 0;
  localparam int ST_OVF = 1;
  localparam int ST_CAP = 2;
  localparam int ST_W   = 3;
  localparam int CTRL_W = 15;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_sel_e;
  typedef enum logic [1:0] {OUT_NONE, OUT_OVF, OUT_OVF_MAT, OUT_RSVD} out_trig_e;

  typedef struct packed {
    logic      pin_dir;
    logic      cap_pair;
    logic      toggle;
    out_trig_e trig;
    edge_sel_e cap_edge;
    logic      idle_lvl;
    logic      cmp_en;
    logic      pre_en;
    logic [2:0] ptv;
    logic      auto_rl;
    logic      start;
  } ctrl_t;

endpackage

// File: rtl/cct_tick.sv
module cct_tick #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int DIV_W = 1 << PTV_W;

  function automatic logic [DIV_W-1:0] div_limit(input logic [PTV_W-1:0] p);
    logic [DIV_W:0] span;
    span = (DIV_W+1)'(1) << (int'(p) + 1);
    return DIV_W'(span - (DIV_W+1)'(1));
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             at_lim;

  assign at_lim = (div_q == div_limit(ptv));
  assign tick   = run & (~pre_en | at_lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                        div_q <= '0;
    else if (!run || !pre_en || at_lim) div_q <= '0;
    else                               div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cct_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_in,
  input  edge_sel_e sel,
  input  logic      pair_mode,
  input  logic      rearm,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap1,
  output logic [W-1:0] cap2,
  output logic      cap1_evt,
  output logic      done_evt
);
  typedef enum logic [1:0] {SLOT_FIRST, SLOT_SECOND, SLOT_DONE} slot_e;

  slot_e slot_q;
  logic  in_q, rise, fall, hit, cap2_evt;

  assign rise = cap_in & ~in_q;
  assign fall = ~cap_in & in_q;

  always_comb begin
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign cap1_evt = hit && (slot_q == SLOT_FIRST);
  assign cap2_evt = hit && (slot_q == SLOT_SECOND) && pair_mode;
  assign done_evt = (cap1_evt && !pair_mode) || cap2_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      slot_q <= SLOT_FIRST;
      cap1   <= '0;
      cap2   <= '0;
    end else begin
      in_q <= cap_in;
      if (cap1_evt) cap1 <= cnt;
      if (cap2_evt) cap2 <= cnt;
      if (rearm)         slot_q <= SLOT_FIRST;
      else if (cap1_evt) slot_q <= pair_mode ? SLOT_SECOND : SLOT_DONE;
      else if (cap2_evt) slot_q <= SLOT_DONE;
    end
  end
endmodule

// File: rtl/cct_wave.sv
module cct_wave
  import cct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  out_trig_e trig,
  input  logic      toggle,
  input  logic      idle_lvl,
  input  logic      ovf_evt,
  input  logic      mat_evt,
  output logic      pwm_out
);
  logic fire, tog_q, pls_q;

  assign fire = ((trig == OUT_OVF) && ovf_evt) ||
                ((trig == OUT_OVF_MAT) && (ovf_evt || mat_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      pls_q <= fire & ~toggle;
      if (!run)                 tog_q <= 1'b0;
      else if (fire && toggle)  tog_q <= ~tog_q;
    end
  end

  assign pwm_out = idle_lvl ^ (toggle ? tog_q : pls_q);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] ld, input logic rl);
    if (&cur) return rl ? ld : '0;
    return cur + 1'b1;
  endfunction

  ctrl_t            ctrl_q, wctrl;
  logic [CNT_W-1:0] cnt_q, load_q, match_q, cap1_q, cap2_q, cnt_step;
  logic [ST_W-1:0]  status_q, ien_q, st_set, st_clr;
  logic wr, ctrl_wr, cnt_wr, load_wr, trg_wr, mat_wr, stat_wr, ien_wr;
  logic tick, ovf_evt, mat_evt, cap1_evt, cap_done, stop_req, rearm;
  logic start_q, auto_rl, pre_en;

  assign wr      = bus_sel & bus_wr;
  assign ctrl_wr = wr && (bus_addr == A_CTRL);
  assign cnt_wr  = wr && (bus_addr == A_CNT);
  assign load_wr = wr && (bus_addr == A_LOAD);
  assign trg_wr  = wr && (bus_addr == A_TRG);
  assign mat_wr  = wr && (bus_addr == A_MAT);
  assign stat_wr = wr && (bus_addr == A_STAT);
  assign ien_wr  = wr && (bus_addr == A_IEN);

  assign wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign start_q = ctrl_q.start;
  assign auto_rl = ctrl_q.auto_rl;
  assign pre_en  = ctrl_q.pre_en;

  cct_tick #(.PTV_W(PTV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(start_q), .pre_en(pre_en),
    .ptv(ctrl_q.ptv), .tick(tick)
  );

  assign cnt_step = step_count(cnt_q, load_q, auto_rl);
  assign ovf_evt  = tick & (&cnt_q);
  assign mat_evt  = tick & ctrl_q.cmp_en & (cnt_step == match_q);
  assign stop_req = ctrl_wr & start_q & ~wctrl.start;
  assign rearm    = stat_wr & bus_wdata[ST_CAP];

  cct_capture #(.W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sel(ctrl_q.cap_edge),
    .pair_mode(ctrl_q.cap_pair), .rearm(rearm), .cnt(cnt_q),
    .cap1(cap1_q), .cap2(cap2_q), .cap1_evt(cap1_evt), .done_evt(cap_done)
  );

  cct_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run(start_q), .trig(ctrl_q.trig),
    .toggle(ctrl_q.toggle), .idle_lvl(ctrl_q.idle_lvl),
    .ovf_evt(ovf_evt), .mat_evt(mat_evt), .pwm_out(pwm_out)
  );

  always_comb begin
    st_set         = '0;
    st_set[ST_MAT] = mat_evt;
    st_set[ST_OVF] = ovf_evt;
    st_set[ST_CAP] = cap_done;
    st_clr         = stat_wr ? bus_wdata[ST_W-1:0] : '0;
    st_clr[ST_OVF] = st_clr[ST_OVF] | stop_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      load_q   <= '0;
      match_q  <= '0;
      status_q <= '0;
      ien_q    <= '0;
    end else begin
      if (ctrl_wr)                ctrl_q <= wctrl;
      else if (ovf_evt && !auto_rl) ctrl_q.start <= 1'b0;

      if (cnt_wr)      cnt_q <= bus_wdata;
      else if (trg_wr) cnt_q <= load_q;
      else if (tick)   cnt_q <= cnt_step;

      if (load_wr) load_q  <= bus_wdata;
      if (mat_wr)  match_q <= bus_wdata;
      if (ien_wr)  ien_q   <= bus_wdata[ST_W-1:0];
      status_q <= (status_q & ~st_clr) | st_set;
    end
  end

  assign irq = |(status_q & ien_q);

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {{(CNT_W-ST_W){1'b0}}, status_q};
      A_IEN:   bus_rdata = {{(CNT_W-ST_W){1'b0}}, ien_q};
      A_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_CNT:   bus_rdata = cnt_q;
      A_LOAD:  bus_rdata = load_q;
      A_MAT:   bus_rdata = match_q;
      A_CAP1:  bus_rdata = cap1_q;
      A_CAP2:  bus_rdata = cap2_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pre_en,
  input logic         run,
  input logic         ovf_evt,
  input logic         auto_rl,
  input logic         ctrl_wr,
  input logic         cnt_wr,
  input logic         trg_wr,
  input logic         cap1_evt,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] load_q,
  input logic [W-1:0] cap1_q,
  input logic [2:0]   status_q
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ovf_evt && !cnt_wr && !trg_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_en && tick && !ctrl_wr) |=> !tick);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && auto_rl && !cnt_wr && !trg_wr) |=> cnt_q == $past(load_q));

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status_q[1]);

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !auto_rl && !ctrl_wr) |=> !run);

  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap1_evt |=> cap1_q == $past(cnt_q));
endmodule

bind cc_timer cct_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pre_en(pre_en), .run(start_q),
  .ovf_evt(ovf_evt), .auto_rl(auto_rl), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
  .trg_wr(trg_wr), .cap1_evt(cap1_evt), .cnt_q(cnt_q), .load_q(load_q),
  .cap1_q(cap1_q), .status_q(status_q)
);

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;
  localparam logic [7:0] STAT = 8'h04, IEN = 8'h08, CTRL = 8'h24, CNT = 8'h28,
                         LOAD = 8'h2C, TRG = 8'h30, MAT = 8'h38, CAP1 = 8'h3C, CAP2 = 8'h44;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, cap_in = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pwm_out, irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cc_timer i_cc_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", CTRL, 0);
    rdchk("R1 count", CNT, 0);
    rdchk("R1 status", STAT, 0);
    rdchk("R1 enable", IEN, 0);
    rdchk("R1 cap1", CAP1, 0);
    rdchk("R1 cap2", CAP2, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pwm", {31'd0, pwm_out}, 0);
  endtask

  task automatic t_count;
    wr(CNT, 100);
    rdchk("R2 counter write", CNT, 100);
    wr(CTRL, 32'h1);
    wait_n(5);
    rdchk("R2 free run", CNT, 105);
    wr(CTRL, 32'h0);
    rdchk("R2 stop value", CNT, 107);
    wait_n(3);
    rdchk("R2 holds stopped", CNT, 107);
  endtask

  task automatic t_prescale;
    wr(CNT, 0);
    wr(CTRL, 32'h25);
    wait_n(3);
    rdchk("R3 before period", CNT, 0);
    wait_n(1);
    rdchk("R3 first step", CNT, 1);
    wait_n(4);
    rdchk("R3 second step", CNT, 2);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_overflow_reload;
    wr(STAT, 7);
    wr(LOAD, 32'h100);
    wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 32'h3);
    wait_n(1);
    rdchk("R4 at top", CNT, 32'hFFFF_FFFF);
    wait_n(1);
    rdchk("R4 reload", CNT, 32'h100);
    rdchk("R4 flag", STAT, 2);
    wr(CTRL, 32'h2);
    rdchk("R12 stop clears ovf", STAT, 0);
    rdchk("R12 other bits kept", CTRL, 2);
  endtask

  task automatic t_overflow_stop;
    wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 32'h1);
    wait_n(2);
    rdchk("R5 wraps to zero", CNT, 0);
    rdchk("R5 run cleared", CTRL, 0);
    rdchk("R5 flag", STAT, 2);
    wr(CTRL, 32'h0);
    rdchk("R12 stopped write keeps ovf", STAT, 2);
    wr(STAT, 1);
    rdchk("R10 zero bits untouched", STAT, 2);
    wr(STAT, 2);
    rdchk("R10 one clears", STAT, 0);
  endtask

  task automatic t_trigger;
    wr(LOAD, 32'h1234);
    wr(CNT, 5);
    wr(TRG, 32'hDEAD);
    rdchk("R6 strobe reload", CNT, 32'h1234);
    rdchk("R6 strobe reads zero", TRG, 0);
  endtask

  task automatic t_match;
    wr(STAT, 7);
    wr(MAT, 13);
    wr(CNT, 10);
    wr(CTRL, 32'h41);
    wait_n(2);
    rdchk("R7 not yet", STAT, 0);
    wait_n(1);
    rdchk("R7 match flag", STAT, 1);
    wr(CTRL, 32'h0);
    wr(STAT, 7);
    wr(CNT, 10);
    wr(CTRL, 32'h1);
    wait_n(4);
    rdchk("R7 compare off", STAT, 0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_status_irq;
    wr(STAT, 7);
    wr(MAT, 3);
    wr(CNT, 2);
    wr(CTRL, 32'h41);
    wr(CTRL, 32'h0);
    rdchk("R7 flag for irq", STAT, 1);
    chk("R11 masked", {31'd0, irq}, 0);
    wr(IEN, 1);
    chk("R11 enabled", {31'd0, irq}, 1);
    wr(IEN, 6);
    chk("R11 other enables", {31'd0, irq}, 0);
    wr(IEN, 1);
    wr(STAT, 1);
    chk("R11 cleared", {31'd0, irq}, 0);
    wr(IEN, 0);
  endtask

  task automatic t_capture;
    cap_in = 1'b0;
    wr(STAT, 7);
    wr(CTRL, 32'h100);
    wr(CNT, 32'h55);
    cap_in = 1'b1;
    wait_n(1);
    rdchk("R8 rising stored", CAP1, 32'h55);
    rdchk("R9 single flag", STAT, 4);
    cap_in = 1'b0;
    wr(CNT, 32'h66);
    cap_in = 1'b1;
    wait_n(1);
    rdchk("R9 later edge ignored", CAP1, 32'h55);
    wr(STAT, 4);
    wr(CTRL, 32'h200);
    wr(CNT, 32'h77);
    cap_in = 1'b0;
    wait_n(1);
    rdchk("R8 falling stored", CAP1, 32'h77);
    wr(STAT, 4);
    wr(CNT, 32'h88);
    cap_in = 1'b1;
    wait_n(1);
    rdchk("R8 rising ignored in falling mode", CAP1, 32'h77);
    rdchk("R8 no flag wrong edge", STAT, 0);
    wr(CTRL, 32'h0);
    cap_in = 1'b0;
    wait_n(1);
    rdchk("R8 none mode value", CAP1, 32'h77);
    rdchk("R8 none mode flag", STAT, 0);
  endtask

  task automatic t_capture_pair;
    cap_in = 1'b0;
    wr(STAT, 4);
    wr(CTRL, 32'h2300);
    wr(CNT, 32'h10);
    cap_in = 1'b1;
    wait_n(1);
    rdchk("R9 pair first", CAP1, 32'h10);
    rdchk("R9 pair no flag yet", STAT, 0);
    wr(CNT, 32'h20);
    cap_in = 1'b0;
    wait_n(1);
    rdchk("R9 pair second", CAP2, 32'h20);
    rdchk("R9 pair flag", STAT, 4);
    wr(CNT, 32'h30);
    cap_in = 1'b1;
    wait_n(1);
    rdchk("R9 pair third ignored", CAP1, 32'h10);
    wr(CTRL, 32'h0);
    wr(STAT, 7);
  endtask

  task automatic t_pwm_toggle;
    wr(LOAD, 32'hFFFF_FFFC);
    wr(CNT, 32'hFFFF_FFFE);
    chk("R13 idle low", {31'd0, pwm_out}, 0);
    wr(CTRL, 32'h1403);
    wait_n(1);
    chk("R13 toggle before ovf", {31'd0, pwm_out}, 0);
    wait_n(1);
    chk("R13 toggle on ovf", {31'd0, pwm_out}, 1);
    wait_n(4);
    chk("R13 toggle back", {31'd0, pwm_out}, 0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_pwm_pulse;
    wr(LOAD, 0);
    wr(MAT, 32'hFFFF_FFFE);
    wr(CNT, 32'hFFFF_FFFD);
    wr(CTRL, 32'h80);
    chk("R13 idle high", {31'd0, pwm_out}, 1);
    wr(CTRL, 32'h8C3);
    wait_n(1);
    chk("R13 pulse on match", {31'd0, pwm_out}, 0);
    wait_n(1);
    chk("R13 pulse ends", {31'd0, pwm_out}, 1);
    wait_n(1);
    chk("R13 pulse on ovf", {31'd0, pwm_out}, 0);
    wait_n(1);
    chk("R13 pulse ends again", {31'd0, pwm_out}, 1);
    wr(CTRL, 32'h80);
    wr(CNT, 32'hFFFF_FFFD);
    wr(CTRL, 32'h4C3);
    wait_n(1);
    chk("R13 match ignored in ovf mode", {31'd0, pwm_out}, 1);
    wait_n(2);
    chk("R13 ovf pulse in ovf mode", {31'd0, pwm_out}, 0);
    wr(CTRL, 32'h0);
    wr(STAT, 7);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_prescale();
    t_overflow_reload();
    t_overflow_stop();
    t_trigger();
    t_match();
    t_status_irq();
    t_capture();
    t_capture_pair();
    t_pwm_toggle();
    t_pwm_pulse();
    finish_run();
  end
endmodule